// File: doc/BRIEF.md
# Multi-Channel Compare Event Timer

This block keeps a free-running 64-bit tick counter and a set of compare channels. Each channel raises a one-cycle interrupt pulse when the counter reaches the channel's comparator value. A channel can fire once (one-shot) or re-arm itself by adding a stored period after every match (periodic). A channel can also compare only the low 32 bits of the counter. Software reaches every control and status value through a flat 32-bit register bus. Writes take effect at the clock edge. Reads are combinational from the address.

Periodic channels are started with a two-step load. Software first writes a configuration word with the load-select flag set. The next comparator write then gives the first match time, and the write after it gives the period. A global routing bit can move channel 0 onto a dedicated system-tick line and channel 1 onto a dedicated calendar-clock line. Software uses this when the timer replaces older fixed-function timers.

Top module: `evt_timer`

## Requirements
- R1: After reset, address 0x000 reads the identity word: bits 7:0 = 0x01, bits 12:8 = channel count minus one, bit 13 = 1 (64-bit counter), bit 15 = routing-capable flag, bits 31:16 = a nonzero vendor code. Address 0x004 reads the tick length in femtoseconds. The global control word at 0x010 reads 0 and the counter reads 0.
- R2: While global control bit 0 (run) is set, the counter at 0x0F0 (low word) / 0x0F4 (high word) advances by one every clock, with a carry from the low word into the high word. While bit 0 is clear, the counter holds its value.
- R3: The counter halves can be written only while run is clear. A counter write made while run is set is ignored.
- R4: Channel i occupies 0x100+0x20*i: control word at +0x00, comparator low word at +0x08, comparator high word at +0x0C. Control word bits: bit 0 = enable, bit 1 = periodic, bit 2 = load-select (write-only, reads 0), bit 3 = 32-bit compare. Bits 8:4 hold a route number on channels 2 and above and read 0 on channels 0 and 1.
- R5: No pulse is produced while run is clear or while the channel's enable bit is clear.
- R6: In one-shot mode, a channel pulses its line high for one cycle, in the cycle after the counter equals the comparator. It pulses once per match. A comparator value that is already behind the counter does not fire until the counter wraps around and reaches it.
- R7: In periodic mode, after a control write with load-select set, the next comparator low-word write loads the comparator and the following write loads the period. A periodic-mode comparator write made without load-select loads the period.
- R8: On a periodic match, the comparator advances by the period at the same edge that raises the pulse, so pulses repeat every period cycles.
- R9: With 32-bit compare set, the match uses only the low 32 bits of the counter and the comparator, and a periodic advance changes only the low word.
- R10: Global control bit 1 (route-override, settable only when routing-capable) sends channel 0's pulse to `legacy_tmr_irq_o` and channel 1's pulse to `legacy_rtc_irq_o`, and holds `irq_o[0]` and `irq_o[1]` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | NUM_CH | Per-channel interrupt pulses |
| legacy_tmr_irq_o | output | 1 | Channel 0 pulse under route-override |
| legacy_rtc_irq_o | output | 1 | Channel 1 pulse under route-override |

## Verification
The bench sets separate values for the first match time and the period. A design that mixed up the two load steps would fire at the wrong first cycle or at the wrong spacing. It preloads the counter just below the 32-bit boundary, so a one-shot comparator sits behind the counter. A full-width compare then misses the match, and a design without wrap handling fires at once. It also leaves an armed comparator on a disabled channel and stops the counter mid-period. A design that ignores either enable would emit a stray pulse that the scoreboard flags. Under route-override, a pulse that still appears on `irq_o[0]` or `irq_o[1]` is reported as unexpected.

// File: rtl/evt_pkg.sv
// Package: register addresses and control-word bit positions shared by the
// timer top, its channels and its bench. Assumes a 12-bit byte address.
package evt_pkg;
    localparam int          AW          = 12;
    localparam logic [11:0] A_IDENT     = 12'h000;
    localparam logic [11:0] A_TICK_FS   = 12'h004;
    localparam logic [11:0] A_GCTL      = 12'h010;
    localparam logic [11:0] A_CNT_LO    = 12'h0F0;
    localparam logic [11:0] A_CNT_HI    = 12'h0F4;
    localparam logic [11:0] A_CH_BASE   = 12'h100;
    localparam int          CH_STRIDE   = 32;
    localparam logic [11:0] OFS_CTL     = 12'h000;
    localparam logic [11:0] OFS_CMP_LO  = 12'h008;
    localparam logic [11:0] OFS_CMP_HI  = 12'h00C;

    localparam int B_EN     = 0;
    localparam int B_PER    = 1;
    localparam int B_LDSEL  = 2;
    localparam int B_W32    = 3;
    localparam int ROUTE_LO = 4;
    localparam int ROUTE_W  = 5;

    // Byte address of a register inside channel idx.
    function automatic logic [11:0] ch_addr(input int idx, input logic [11:0] ofs);
        return A_CH_BASE + 12'(idx * CH_STRIDE) + ofs;
    endfunction
endpackage

// File: rtl/evt_main_counter.sv
// Module: 64-bit tick counter. Counts while run is high; otherwise accepts
// writes of either 32-bit half. Assumes the caller gates writes with !run.
module evt_main_counter #(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [31:0]   wdata,
    output logic [CW-1:0] cnt
);
    localparam int HW = CW / 2;

    // Advance while running, else load a half on request.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (run)    cnt <= cnt + CW'(1);
        else if (wr_lo)  cnt[HW-1:0]  <= wdata[HW-1:0];
        else if (wr_hi)  cnt[CW-1:HW] <= wdata[HW-1:0];
    end

    // R2
    run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> cnt == $past(cnt) + CW'(1));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> $stable(cnt));
endmodule

// File: rtl/evt_channel.sv
// Module: one compare channel. Holds its control bits, comparator and period,
// and raises a one-cycle pulse the cycle after the running counter equals the
// comparator. Assumes the counter moves by one per cycle while run is high.
module evt_channel
    import evt_pkg::*;
#(
    parameter int CW        = 64,
    parameter bit HAS_ROUTE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] cnt,
    input  logic          wr_ctl,
    input  logic          wr_cmp_lo,
    input  logic          wr_cmp_hi,
    input  logic [31:0]   wdata,
    output logic [31:0]   ctl_rd,
    output logic [CW-1:0] cmp_rd,
    output logic          irq
);
    localparam int HW = CW / 2;

    logic               en, per, w32, ldsel;
    logic [ROUTE_W-1:0] route;
    logic [CW-1:0]      cmp, prd;
    logic               hit, to_prd;

    // Match detect: only while counting and enabled, width per mode.
    always_comb begin
        hit = run && en && (w32 ? (cnt[HW-1:0] == cmp[HW-1:0]) : (cnt == cmp));
        to_prd = per && !ldsel;
    end

    // Control word and load-select arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0; per <= 1'b0; w32 <= 1'b0; ldsel <= 1'b0; route <= '0;
        end else if (wr_ctl) begin
            en    <= wdata[B_EN];
            per   <= wdata[B_PER];
            w32   <= wdata[B_W32];
            ldsel <= wdata[B_LDSEL];
            route <= HAS_ROUTE ? wdata[ROUTE_LO +: ROUTE_W] : '0;
        end else if (wr_cmp_lo) begin
            ldsel <= 1'b0;
        end
    end

    // Comparator and period: bus loads first, then periodic advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp <= '0; prd <= '0;
        end else if (wr_cmp_lo) begin
            if (to_prd) prd[HW-1:0] <= wdata[HW-1:0];
            else        cmp[HW-1:0] <= wdata[HW-1:0];
        end else if (wr_cmp_hi) begin
            if (to_prd) prd[CW-1:HW] <= wdata[HW-1:0];
            else        cmp[CW-1:HW] <= wdata[HW-1:0];
        end else if (hit && per) begin
            if (w32) cmp[HW-1:0] <= cmp[HW-1:0] + prd[HW-1:0];
            else     cmp         <= cmp + prd;
        end
    end

    // Registered pulse, one cycle per match.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= hit;
    end

    // Readback views.
    always_comb begin
        ctl_rd = '0;
        ctl_rd[B_EN]  = en;
        ctl_rd[B_PER] = per;
        ctl_rd[B_W32] = w32;
        ctl_rd[ROUTE_LO +: ROUTE_W] = route;
        cmp_rd = cmp;
    end

    // R5
    pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(run && en));
    // R6
    oneshot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !per && !$past(wr_cmp_lo || wr_cmp_hi)) |=> !irq);
    // R8
    period_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(per && !w32) && !$past(wr_cmp_lo || wr_cmp_hi || wr_ctl))
        |-> cmp == $past(cmp) + prd);
endmodule

// File: rtl/evt_timer.sv
// Module: timer top. Decodes the register bus, owns the global control bits,
// instantiates the counter and NUM_CH channels, and routes their pulses.
// Assumes 2 <= NUM_CH <= 32 and 32-bit register accesses.
module evt_timer
    import evt_pkg::*;
#(
    parameter int          NUM_CH     = 3,
    parameter int          TICK_FS    = 10_000_000,
    parameter logic [15:0] VENDOR     = 16'h5A17,
    parameter bit          ROUTE_CAP  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq_o,
    output logic              legacy_tmr_irq_o,
    output logic              legacy_rtc_irq_o
);
    localparam int          CW       = 64;
    localparam logic [31:0] IDENT    = {VENDOR, ROUTE_CAP, 1'b0, 1'b1,
                                        5'(NUM_CH - 1), 8'h01};

    logic          g_run, g_route;
    logic [CW-1:0] cnt;
    logic [31:0]   ch_ctl [NUM_CH];
    logic [CW-1:0] ch_cmp [NUM_CH];
    logic [NUM_CH-1:0] ch_irq;

    // Global control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_run <= 1'b0; g_route <= 1'b0;
        end else if (bus_wr && bus_addr == A_GCTL) begin
            g_run   <= bus_wdata[0];
            g_route <= ROUTE_CAP & bus_wdata[1];
        end
    end

    evt_main_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (g_run),
        .wr_lo (bus_wr && !g_run && bus_addr == A_CNT_LO),
        .wr_hi (bus_wr && !g_run && bus_addr == A_CNT_HI),
        .wdata (bus_wdata),
        .cnt   (cnt)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        evt_channel #(.CW(CW), .HAS_ROUTE(i >= 2)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (g_run),
            .cnt       (cnt),
            .wr_ctl    (bus_wr && bus_addr == ch_addr(i, OFS_CTL)),
            .wr_cmp_lo (bus_wr && bus_addr == ch_addr(i, OFS_CMP_LO)),
            .wr_cmp_hi (bus_wr && bus_addr == ch_addr(i, OFS_CMP_HI)),
            .wdata     (bus_wdata),
            .ctl_rd    (ch_ctl[i]),
            .cmp_rd    (ch_cmp[i]),
            .irq       (ch_irq[i])
        );
    end

    // Read mux over globals and every channel.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_IDENT:   bus_rdata = IDENT;
            A_TICK_FS: bus_rdata = 32'(TICK_FS);
            A_GCTL:    bus_rdata = {30'b0, g_route, g_run};
            A_CNT_LO:  bus_rdata = cnt[31:0];
            A_CNT_HI:  bus_rdata = cnt[63:32];
            default:   bus_rdata = '0;
        endcase
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ch_addr(i, OFS_CTL))    bus_rdata = ch_ctl[i];
            if (bus_addr == ch_addr(i, OFS_CMP_LO)) bus_rdata = ch_cmp[i][31:0];
            if (bus_addr == ch_addr(i, OFS_CMP_HI)) bus_rdata = ch_cmp[i][63:32];
        end
    end

    // Pulse routing: override moves channels 0 and 1 to the dedicated lines.
    always_comb begin
        irq_o = ch_irq;
        if (g_route) irq_o[1:0] = 2'b00;
        legacy_tmr_irq_o = g_route & ch_irq[0];
        legacy_rtc_irq_o = g_route & ch_irq[1];
    end

    // R10
    route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_tmr_irq_o || legacy_rtc_irq_o) |-> (irq_o[1:0] == 2'b00));
    // R5
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!g_run && !$past(g_run)) |-> (irq_o == '0 && !legacy_tmr_irq_o && !legacy_rtc_irq_o));
endmodule

// File: tb/evt_timer_test.sv
`timescale 1ns/1ps
module evt_timer_test;
    import evt_pkg::*;
    localparam int NCH = 3;

    logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    wire  [31:0] bus_rdata;
    wire  [NCH-1:0] irq_o;
    wire         leg_tmr, leg_rtc;

    evt_timer #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
        .legacy_tmr_irq_o(leg_tmr), .legacy_rtc_irq_o(leg_rtc)
    );

    always #2 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    typedef struct { int line; int unsigned at; string req; } exp_t;
    exp_t sb[$];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic push(input int line, input int unsigned at, input string req);
        exp_t e; e.line = line; e.at = at; e.req = req; sb.push_back(e);
    endtask

    task automatic wait_until(input int unsigned c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Monitor: compare every pulse against the scoreboard front.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NCH+1:0] lines;
            lines = {leg_rtc, leg_tmr, irq_o};
            if (sb.size() > 0 && sb[0].at < cyc) begin
                n_chk++; n_bad++;
                $display("FAIL %s: line %0d silent at cycle %0d, expected pulse", sb[0].req, sb[0].line, sb[0].at);
                void'(sb.pop_front());
            end
            for (int l = 0; l < NCH + 2; l++) begin
                if (lines[l]) begin
                    n_chk++;
                    if (sb.size() > 0 && sb[0].line == l && sb[0].at == cyc) begin
                        void'(sb.pop_front());
                    end else begin
                        n_bad++;
                        $display("FAIL R5: pulse on line %0d at cycle %0d, expected none", l, cyc);
                    end
                end
            end
        end
    end

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
    end

    initial begin
        logic [31:0] v, v2;
        int unsigned en;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and identity
        rd(A_IDENT, v);   chk("R1", v, {16'h5A17, 1'b1, 1'b0, 1'b1, 5'd2, 8'h01});
        rd(A_TICK_FS, v); chk("R1", v, 32'd10_000_000);
        rd(A_GCTL, v);    chk("R1", v, 0);
        rd(A_CNT_LO, v);  chk("R1", v, 0);
        repeat (5) @(negedge clk);
        rd(A_CNT_LO, v);  chk("R2", v, 0);

        // R3 counter loads while stopped
        wr(A_CNT_LO, 32'h10); wr(A_CNT_HI, 32'h2);
        rd(A_CNT_LO, v); chk("R3", v, 32'h10);
        rd(A_CNT_HI, v); chk("R3", v, 32'h2);
        wr(A_CNT_LO, 0); wr(A_CNT_HI, 0);

        // R6 one-shot on ch2, R7 periodic load sequence on ch0
        wr(ch_addr(2, OFS_CTL), 32'h1);
        wr(ch_addr(2, OFS_CMP_LO), 32'd20);
        wr(ch_addr(0, OFS_CTL), 32'h7);
        wr(ch_addr(0, OFS_CMP_LO), 32'd30);
        wr(ch_addr(0, OFS_CMP_LO), 32'd12);
        rd(ch_addr(0, OFS_CTL), v);    chk("R4", v, 32'h3);
        rd(ch_addr(0, OFS_CMP_LO), v); chk("R7", v, 32'd30);
        wr(A_GCTL, 32'h1); en = cyc;
        push(2, en + 21, "R6");
        push(0, en + 31, "R7");
        push(0, en + 43, "R8");
        push(0, en + 55, "R8");
        rd(A_CNT_LO, v); chk("R2", v, 32'(cyc - en));
        wr(A_CNT_LO, 32'hABC);
        rd(A_CNT_LO, v); chk("R3", v, 32'(cyc - en));
        wait_until(en + 58);
        wr(A_GCTL, 32'h0);
        rd(A_CNT_LO, v); repeat (5) @(negedge clk);
        rd(A_CNT_LO, v2); chk("R2", v2, v);
        repeat (15) @(negedge clk);
        rd(ch_addr(0, OFS_CMP_LO), v); chk("R8", v, 32'd66);

        // R9 32-bit compare across wrap; R5 disabled channel stays quiet
        wr(ch_addr(0, OFS_CTL), 32'h0);
        wr(ch_addr(2, OFS_CTL), 32'h0);
        wr(ch_addr(0, OFS_CMP_LO), 32'hFFFF_FFF4);
        wr(A_CNT_LO, 32'hFFFF_FFF0); wr(A_CNT_HI, 0);
        wr(ch_addr(2, OFS_CTL), 32'h9);
        wr(ch_addr(2, OFS_CMP_LO), 32'd5);
        wr(ch_addr(1, OFS_CTL), 32'h1);
        wr(ch_addr(1, OFS_CMP_LO), 32'hFFFF_FFF8);
        wr(A_GCTL, 32'h1); en = cyc;
        push(1, en + 9,  "R6");
        push(2, en + 22, "R9");
        wait_until(en + 40);
        wr(A_GCTL, 32'h0);
        rd(A_CNT_HI, v); chk("R2", v, 32'h1);

        // R10 route-override
        wr(ch_addr(1, OFS_CTL), 32'h0);
        wr(ch_addr(2, OFS_CTL), 32'h0);
        wr(A_CNT_LO, 0); wr(A_CNT_HI, 0);
        wr(ch_addr(0, OFS_CTL), 32'h1);
        wr(ch_addr(0, OFS_CMP_LO), 32'd10);
        wr(ch_addr(1, OFS_CTL), 32'h1);
        wr(ch_addr(1, OFS_CMP_LO), 32'd15);
        wr(A_GCTL, 32'h3); en = cyc;
        push(NCH,     en + 11, "R10");
        push(NCH + 1, en + 16, "R10");
        rd(A_GCTL, v); chk("R10", v, 32'h3);
        wait_until(en + 30);
        wr(A_GCTL, 32'h0);

        // R4 route field presence per channel
        wr(ch_addr(2, OFS_CTL), 32'h50);
        rd(ch_addr(2, OFS_CTL), v); chk("R4", v, 32'h50);
        wr(ch_addr(0, OFS_CTL), 32'h50);
        rd(ch_addr(0, OFS_CTL), v); chk("R4", v, 32'h0);

        repeat (5) @(negedge clk);
        chk("R6", 64'(sb.size()), 0);
        summary();
    end
endmodule